// File: doc/BRIEF.md
# Serial-Bus Eight-Bit Port Expander

This block is a two-wire serial-bus slave that provides eight general-purpose pins to a host controller. It oversamples the clock and data lines with the system clock and pulls the data line low through an open-drain enable. The 7-bit slave address is a fixed upper nibble of `0100` followed by three strap inputs. This lets up to eight of these blocks share one bus.

A write transfer copies every received data byte into the output latch, and the latch holds its value between transfers. A read transfer returns the pin levels, masked by the latch. A pin whose latch bit is high is weakly pulled up and behaves as an input. A pin whose latch bit is low is forced low. The open-drain interrupt output is active low. It pulls low when the masked input levels differ from the value last read or written, so the host learns of new input without polling.

Top module: `io_expander`

## Requirements
- R1: After reset, every bit of `port_o` is 1, `sda_oe_o` is 0 and `int_pull_o` is 0.
- R2: The slave acknowledges (pulls SDA low through the ninth clock) only an address byte whose upper seven bits equal {4'b0100, addr_strap_i}. Bit 0 of that byte is the direction (1 = read, 0 = write). With any other address the slave never pulls SDA and ignores the bytes that follow until the next start.
- R3: In a write, every data byte after the address is acknowledged and appears on `port_o` by the end of its acknowledge clock. Any number of bytes may follow.
- R4: In a read, each returned byte is `port_i & port_o`, sent MSB first. It is sampled at the acknowledge clock that precedes that byte: the address acknowledge for the first byte, and the previous master acknowledge for each later byte.
- R5: After the master does not acknowledge a read byte, the slave keeps SDA released until a stop or a start.
- R6: A start condition in the middle of a transfer restarts address reception, so a repeated start can switch from write to read.
- R7: `int_pull_o` goes to 1 within 4 clocks when the masked input level changes. A pin whose latch bit is 0 cannot raise it.
- R8: Any read or write to this slave clears the interrupt. The interrupt also clears when the masked inputs return to the last value read or written.
- R9: The slave begins pulling SDA low only while SCL is low.
- R10: A stop condition in the middle of a data byte discards that byte, and `port_o` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the bus |
| rst_ni | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| addr_strap_i | input | 3 | Low three address bits |
| port_i | input | 8 | Pin levels observed at the pads |
| port_o | output | 8 | Output latch (1 = weak high / input) |
| int_pull_o | output | 1 | 1 pulls the active-low interrupt line low |

## Verification
A wrong bit counter or state shows up on the bus within one byte: an acknowledge lands in the wrong clock, a data bit shifts by one position, or a write latches a partial or misaligned byte on `port_o`. A stale read snapshot or interrupt reference shows up as a returned byte that lags the pins by one transfer, or as `int_pull_o` staying set after an access. The bench checks these at the end of each acknowledge clock, and checks the interrupt a few clocks after each change at the pins.

// File: rtl/io_exp_pkg.sv
package io_exp_pkg;
  localparam int BYTE_W = 8;
  localparam int STRAP_W = 3;
  localparam logic [3:0] ADDR_PREFIX = 4'b0100;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WDATA,
    ST_WACK,
    ST_RDATA,
    ST_RACK,
    ST_WAIT
  } bus_state_e;
endpackage

// File: rtl/io_exp_sync.sv
module io_exp_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/io_exp_bus.sv
module io_exp_bus
  import io_exp_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               sda_i,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  rd_data_i,
  output logic               wr_stb_o,
  output logic [BYTE_W-1:0]  wr_data_o,
  output logic               rd_cap_o,
  output logic               sda_oe_o
);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(BYTE_W);

  bus_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BYTE_W-1:0] shift_q;
  logic              scl_d, sda_d;
  logic              rw_q, mack_q, sda_oe_q, wr_stb_q, rd_cap_q;
  logic              scl_rise, scl_fall, start_ev, stop_ev, addr_hit;

  assign scl_rise = scl_i & ~scl_d;
  assign scl_fall = ~scl_i & scl_d;
  assign start_ev = scl_i & scl_d & sda_d & ~sda_i;
  assign stop_ev  = scl_i & scl_d & ~sda_d & sda_i;
  assign addr_hit = (shift_q[BYTE_W-1:1] == {ADDR_PREFIX, strap_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      shift_q  <= '0;
      rw_q     <= 1'b0;
      mack_q   <= 1'b0;
      sda_oe_q <= 1'b0;
      wr_stb_q <= 1'b0;
      rd_cap_q <= 1'b0;
    end else begin
      wr_stb_q <= 1'b0;
      rd_cap_q <= 1'b0;
      if (start_ev) begin
        state_q  <= ST_ADDR;
        cnt_q    <= '0;
        sda_oe_q <= 1'b0;
      end else if (stop_ev) begin
        state_q  <= ST_IDLE;
        sda_oe_q <= 1'b0;
      end else begin
        unique case (state_q)
          ST_ADDR, ST_WDATA: begin
            if (scl_rise && cnt_q != FULL_CNT) begin
              shift_q <= {shift_q[BYTE_W-2:0], sda_i};
              cnt_q   <= cnt_q + 1'b1;
            end else if (scl_fall && cnt_q == FULL_CNT) begin
              cnt_q <= '0;
              if (state_q == ST_ADDR) begin
                if (addr_hit) begin
                  state_q  <= ST_AACK;
                  sda_oe_q <= 1'b1;
                  rw_q     <= shift_q[0];
                  rd_cap_q <= shift_q[0];
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                state_q  <= ST_WACK;
                sda_oe_q <= 1'b1;
                wr_stb_q <= 1'b1;
              end
            end
          end
          ST_AACK, ST_WACK: begin
            if (scl_fall) begin
              cnt_q <= '0;
              if (rw_q) begin
                state_q  <= ST_RDATA;
                shift_q  <= rd_data_i;
                sda_oe_q <= ~rd_data_i[BYTE_W-1];
              end else begin
                state_q  <= ST_WDATA;
                sda_oe_q <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (scl_fall) begin
              if (cnt_q == LAST_BIT) begin
                state_q  <= ST_RACK;
                sda_oe_q <= 1'b0;
                rd_cap_q <= 1'b1;
              end else begin
                cnt_q    <= cnt_q + 1'b1;
                shift_q  <= {shift_q[BYTE_W-2:0], 1'b0};
                sda_oe_q <= ~shift_q[BYTE_W-2];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_i;
            if (scl_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                state_q  <= ST_RDATA;
                shift_q  <= rd_data_i;
                sda_oe_q <= ~rd_data_i[BYTE_W-1];
              end else begin
                state_q <= ST_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign wr_stb_o  = wr_stb_q;
  assign wr_data_o = shift_q;
  assign rd_cap_o  = rd_cap_q;
  assign sda_oe_o  = sda_oe_q;

  assert_pull_scl_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sda_oe_q) |-> !scl_i);
  assert_nack_released_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT) |-> !sda_oe_q);
  assert_strobe_exclusive_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({wr_stb_q, rd_cap_q}));
  assert_ack_on_match_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AACK) |-> (shift_q[BYTE_W-1:1] == {ADDR_PREFIX, strap_i}));
endmodule

// File: rtl/io_exp_port.sv
module io_exp_port
  import io_exp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] pin_i,
  input  logic              wr_stb_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_cap_i,
  output logic [BYTE_W-1:0] port_o,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic              int_o
);
  logic [BYTE_W-1:0] out_q, snap_q, ref_q, lvl;
  logic              int_q;

  // a latched low forces the pin low
  assign lvl = pin_i & out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '1;
      snap_q <= '1;
      ref_q  <= '1;
      int_q  <= 1'b0;
    end else begin
      int_q <= (lvl != ref_q);
      if (wr_stb_i) begin
        out_q <= wr_data_i;
        ref_q <= pin_i & wr_data_i;
      end else if (rd_cap_i) begin
        snap_q <= lvl;
        ref_q  <= lvl;
      end
    end
  end

  assign port_o    = out_q;
  assign rd_data_o = snap_q;
  assign int_o     = int_q;

  assert_latch_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_stb_i |=> $stable(out_q));
  assert_snap_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_cap_i |=> $stable(snap_q));
endmodule

// File: rtl/io_expander.sv
module io_expander
  import io_exp_pkg::*;
(
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         scl_i,
  input  logic         sda_i,
  output logic         sda_oe_o,
  input  logic [2:0]   addr_strap_i,
  input  logic [7:0]   port_i,
  output logic [7:0]   port_o,
  output logic         int_pull_o
);
  logic [1:0]        bus_s;
  logic [BYTE_W-1:0] pin_s, wr_data, rd_data;
  logic              wr_stb, rd_cap;

  io_exp_sync #(.WIDTH(2), .RST_VAL(2'b11)) u_bus_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i({scl_i, sda_i}), .q_o(bus_s)
  );

  io_exp_sync #(.WIDTH(BYTE_W), .RST_VAL('1)) u_pin_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(port_i), .q_o(pin_s)
  );

  io_exp_bus u_bus (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .scl_i(bus_s[1]), .sda_i(bus_s[0]),
    .strap_i(addr_strap_i), .rd_data_i(rd_data),
    .wr_stb_o(wr_stb), .wr_data_o(wr_data),
    .rd_cap_o(rd_cap), .sda_oe_o(sda_oe_o)
  );

  io_exp_port u_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .pin_i(pin_s),
    .wr_stb_i(wr_stb), .wr_data_i(wr_data), .rd_cap_i(rd_cap),
    .port_o(port_o), .rd_data_o(rd_data), .int_o(int_pull_o)
  );
endmodule

// File: tb/sim_io_expander.sv
module sim_io_expander;
  localparam int CLK_P = 10;
  localparam int Q = 5;
  localparam logic [7:0] AW = 8'h4A;
  localparam logic [7:0] AR = 8'h4B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_drv = 1'b1, sda_drv = 1'b1;
  logic sda_oe, int_pull, sda_bus;
  logic [2:0] strap = 3'b101;
  logic [7:0] port_in = 8'hFF;
  logic [7:0] port_out;
  int tests = 0, fails = 0, r9_viol = 0;
  logic [7:0] exp_q[$];
  string tag_q[$];
  logic [7:0] got_byte;
  event rd_ev;

  always #(CLK_P/2) clk = ~clk;
  assign sda_bus = sda_drv & ~sda_oe;

  io_expander u0 (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_drv), .sda_i(sda_bus),
    .sda_oe_o(sda_oe), .addr_strap_i(strap), .port_i(port_in),
    .port_o(port_out), .int_pull_o(int_pull)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // scoreboard monitor for read bytes
  initial forever begin
    @(rd_ev);
    if (exp_q.size() == 0) check(1'b0, "R4 unexpected byte", got_byte, 8'h00);
    else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string t = tag_q.pop_front();
      check(got_byte == e, t, got_byte, e);
    end
  end

  // R9: slave must never begin pulling while SCL is high
  always @(posedge clk) if (rst_n && scl_drv && sda_oe && !$past(sda_oe)) r9_viol++;

  task automatic wq(); repeat (Q) @(negedge clk); endtask
  task automatic i2c_start();
    sda_drv = 1; wq(); scl_drv = 1; wq(); sda_drv = 0; wq(); scl_drv = 0; wq();
  endtask
  task automatic i2c_stop();
    sda_drv = 0; wq(); scl_drv = 1; wq(); sda_drv = 1; wq();
  endtask
  task automatic wbit(input logic b);
    sda_drv = b; wq(); scl_drv = 1; wq(); wq(); scl_drv = 0; wq();
  endtask
  task automatic rbit(output logic b);
    sda_drv = 1; wq(); scl_drv = 1; wq(); b = sda_bus; wq(); scl_drv = 0; wq();
  endtask
  task automatic send(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) wbit(d[i]);
    rbit(b);
    ack = ~b;
  endtask
  task automatic recv(input logic [7:0] e, input string t, input logic mack);
    logic b;
    exp_q.push_back(e);
    tag_q.push_back(t);
    for (int i = 7; i >= 0; i--) begin
      rbit(b);
      got_byte[i] = b;
    end
    -> rd_ev;
    wbit(~mack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog", 8'h00, 8'h01);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic ack, b;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(port_out == 8'hFF, "R1 port reset", port_out, 8'hFF);
    check(!sda_oe && !int_pull, "R1 sda/int released", {6'd0, sda_oe, int_pull}, 8'h00);

    // R2/R3 write two bytes
    i2c_start(); send(AW, ack);
    check(ack, "R2 address ack", {7'd0, ack}, 8'h01);
    send(8'hA5, ack);
    check(ack && port_out == 8'hA5, "R3 first byte", port_out, 8'hA5);
    send(8'h3C, ack);
    check(ack && port_out == 8'h3C, "R3 second byte", port_out, 8'h3C);
    i2c_stop();

    // R2 foreign address ignored
    i2c_start(); send(8'h40, ack);
    check(!ack, "R2 no ack foreign", {7'd0, ack}, 8'h00);
    send(8'h00, ack);
    check(!ack && port_out == 8'h3C, "R2 data ignored", port_out, 8'h3C);
    i2c_stop();

    // R4 read two bytes, pins change between bytes
    port_in = 8'hF0;
    i2c_start(); send(AR, ack);
    port_in = 8'h0F;
    recv(8'h30, "R4 first read byte", 1'b1);
    recv(8'h0C, "R4 resampled byte", 1'b0);
    i2c_stop();
    repeat (6) @(negedge clk);
    check(!int_pull, "R8 cleared after read", {7'd0, int_pull}, 8'h00);

    // R5 nack then released
    i2c_start(); send(AR, ack);
    recv(8'h0C, "R4 masked read", 1'b0);
    check(!sda_oe, "R5 released after nack", {7'd0, sda_oe}, 8'h00);
    rbit(b);
    check(b == 1'b1, "R5 stays released", {7'd0, b}, 8'h01);
    i2c_stop();

    // R7/R8 interrupt
    port_in = 8'h07; repeat (6) @(negedge clk);
    check(int_pull, "R7 input change", {7'd0, int_pull}, 8'h01);
    port_in = 8'h0F; repeat (6) @(negedge clk);
    check(!int_pull, "R8 returned to read value", {7'd0, int_pull}, 8'h00);
    port_in = 8'h8F; repeat (6) @(negedge clk);
    check(!int_pull, "R7 masked pin", {7'd0, int_pull}, 8'h00);
    port_in = 8'h0B; repeat (6) @(negedge clk);
    check(int_pull, "R7 second change", {7'd0, int_pull}, 8'h01);
    i2c_start(); send(AR, ack);
    recv(8'h08, "R4 read after change", 1'b0);
    i2c_stop();
    repeat (6) @(negedge clk);
    check(!int_pull, "R8 read clears", {7'd0, int_pull}, 8'h00);

    // R10 stop inside a byte
    i2c_start(); send(AW, ack);
    for (int i = 0; i < 4; i++) wbit(1'b0);
    i2c_stop();
    repeat (4) @(negedge clk);
    check(port_out == 8'h3C, "R10 partial byte dropped", port_out, 8'h3C);

    // R6 repeated start write -> read
    i2c_start(); send(AW, ack);
    send(8'hFF, ack);
    check(ack && port_out == 8'hFF, "R6 write before restart", port_out, 8'hFF);
    port_in = 8'h5A;
    i2c_start(); send(AR, ack);
    check(ack, "R6 restart address ack", {7'd0, ack}, 8'h01);
    recv(8'h5A, "R6 read after restart", 1'b0);
    i2c_stop();
    repeat (6) @(negedge clk);

    check(exp_q.size() == 0, "R4 all bytes seen", 8'(exp_q.size()), 8'h00);
    check(r9_viol == 0, "R9 pull begins with SCL low", 8'(r9_viol), 8'h00);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule